// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block produces the word-address stream for a synchronous burst read from a 16-bit-wide memory. A start request captures a starting word address. From the next clock onward the block presents one address per clock. The order of those addresses follows a latched burst length and a wrap/linear choice. Wrapping bursts stay inside their aligned group of 4, 8 or 16 words. Linear bursts run straight through.

A linear burst that starts off a 4-word alignment and crosses a 16-word boundary needs extra cycles at the crossing. The block inserts those idle cycles and flags them on a ready/wait pin. The active level of that pin is configurable, and so is its timing: on the idle cycle itself, or one clock ahead of it. The sequence pauses while the read-output enable is low, which stands in for a stopped clock, and continues from the held address when the enable returns. A mode input selects asynchronous reads; in that mode the sequencer stays idle. A chip-select input gates the whole block, and the ready/wait pin is released (its output enable is low) while the chip is not selected.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset no burst is active: `beatValid` is 0 and `rdyWait` sits at its deasserted level (the inverse of `cfgWaitPol`) while `chipSel` is high.
- R2: A `startReq` sampled high at a rising edge while `chipSel` is 1 and `cfgAsync` is 0 loads `startAddr`. After that edge `wordAddr` equals `startAddr` with `beatValid` 1, and each later edge with `outEn` high presents the next address of the sequence.
- R3: `cfgLen` encodes the burst length: 3'b001 is 4 beats, 3'b010 is 8, 3'b011 is 16, and 3'b111 (and every other code) is continuous. A finite burst drops `beatValid` on the cycle after its last beat.
- R4: With `cfgWrap` = 1 on a finite burst, only the low log2(length) bits of the address count up, modulo the length. The higher bits never change, and no wait cycles occur (start offset 1 of 4 gives 1-2-3-0; offset 2 gives 2-3-0-1).
- R5: With `cfgWrap` = 0 the address increases by one per beat. A burst that crosses no 16-word boundary has no wait cycles (4 beats from offset 1 give 1-2-3-4).
- R6: In a linear burst, the first crossing of a 16-word boundary inserts `startAddr[1:0]` wait cycles. During a wait cycle `beatValid` is 0 and `wordAddr` already shows the next address. Later crossings add no waits (offset 13 gives 13-14-15-W-16; offset 14 gives 14-15-W-W-16-17).
- R7: A continuous burst always runs linearly, whatever the value of `cfgWrap`.
- R8: When `cfgWaitPol` is 1, `rdyWait` is high when asserted and low otherwise. When `cfgWaitPol` is 0 the levels are reversed.
- R9: With `cfgWaitEarly` = 0, `rdyWait` is asserted exactly on wait cycles. With `cfgWaitEarly` = 1 it is asserted exactly on the cycles that directly precede a wait cycle.
- R10: While `outEn` is 0, the presented address, the remaining beat count and the pending waits are held. The burst resumes from the held address once `outEn` returns to 1.
- R11: While `cfgAsync` is 1 (asynchronous reads; 0 is the power-on default), `startReq` is ignored and no burst starts.
- R12: `rdyWaitOe` equals `chipSel`. A clock edge with `chipSel` at 0 ends any burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Capture `startAddr` and begin a burst |
| startAddr | input | ADDR_W | Starting word address |
| cfgAsync | input | 1 | 1 selects asynchronous reads (sequencer idle) |
| cfgLen | input | 3 | Burst length code |
| cfgWrap | input | 1 | 1 selects wrapping order |
| cfgWaitPol | input | 1 | Active level of `rdyWait` |
| cfgWaitEarly | input | 1 | 1 asserts `rdyWait` one clock before a wait cycle |
| chipSel | input | 1 | Chip enable, active high |
| outEn | input | 1 | Read-output enable; low pauses the burst |
| wordAddr | output | ADDR_W | Presented word address |
| beatValid | output | 1 | Presented address is a real beat |
| rdyWait | output | 1 | Ready/wait indication |
| rdyWaitOe | output | 1 | Drive enable of `rdyWait` (low means released) |

## Verification
The address, `beatValid` and the waits pass through one register stage. The first address therefore appears after the rising edge that samples `startReq`, and each later sequence element appears one edge after the one before it. `rdyWait` and `rdyWaitOe` are combinational from that state and from the live polarity, timing and chip-select inputs, so they change in the same cycle as the state or input they depend on. The bench changes inputs and samples outputs only on the falling edge. It compares the sample taken after the n-th rising edge with the n-th expected element. For early mode, the expected pin level for a cycle comes from looking one element ahead in that list.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BLOCK_W = 4;            // 16-word boundary
  localparam int SKEW_W  = 2;            // misalignment within a 4-word group
  localparam int LEN_W   = 3;
  localparam int BEAT_W  = BLOCK_W + 1;

  localparam logic [LEN_W-1:0] LEN_4    = 3'b001;
  localparam logic [LEN_W-1:0] LEN_8    = 3'b010;
  localparam logic [LEN_W-1:0] LEN_16   = 3'b011;
  localparam logic [LEN_W-1:0] LEN_CONT = 3'b111;

  typedef struct packed {
    logic               load;
    logic               advance;
    logic               wrapEn;
    logic [BLOCK_W-1:0] wrapMask;
  } seqStrobe_t;

  typedef struct packed {
    logic               cont;
    logic [BEAT_W-1:0]  beats;
    logic [BLOCK_W-1:0] mask;
  } lenInfo_t;

  function automatic lenInfo_t decodeLen(input logic [LEN_W-1:0] code);
    lenInfo_t r;
    r.cont  = 1'b0;
    r.beats = BEAT_W'(4);
    r.mask  = BLOCK_W'(3);
    case (code)
      LEN_4:   begin r.beats = BEAT_W'(4);  r.mask = BLOCK_W'(3);  end
      LEN_8:   begin r.beats = BEAT_W'(8);  r.mask = BLOCK_W'(7);  end
      LEN_16:  begin r.beats = BEAT_W'(16); r.mask = BLOCK_W'(15); end
      default: begin r.cont = 1'b1; r.beats = BEAT_W'(0); r.mask = BLOCK_W'(0); end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              atBlockEnd
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] incr;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    incr = addrQ + ADDR_W'(1);
    if (strobe.wrapEn)
      nextAddr = {addrQ[ADDR_W-1:BLOCK_W],
                  (addrQ[BLOCK_W-1:0] & ~strobe.wrapMask) |
                  (incr[BLOCK_W-1:0] & strobe.wrapMask)};
    else
      nextAddr = incr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                addrQ <= '0;
    else if (strobe.load)     addrQ <= startAddr;
    else if (strobe.advance)  addrQ <= nextAddr;
  end

  assign wordAddr   = addrQ;
  assign atBlockEnd = &addrQ[BLOCK_W-1:0];

  AST_WRAP_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.wrapEn && !strobe.load) |=> $stable(addrQ[ADDR_W-1:BLOCK_W])); // R4
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [SKEW_W-1:0] startSkew,
  input  logic              cfgAsync,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgWrap,
  input  logic              cfgWaitPol,
  input  logic              cfgWaitEarly,
  input  logic              chipSel,
  input  logic              outEn,
  input  logic              atBlockEnd,
  output seqStrobe_t        strobe,
  output logic              beatValid,
  output logic              rdyWait,
  output logic              rdyWaitOe
);
  logic               active, inWait, contMode, wrapEff;
  logic [SKEW_W-1:0]  waitLeft;
  logic [BEAT_W-1:0]  beatsLeft;
  logic [BLOCK_W-1:0] maskQ;
  lenInfo_t           lenNow;

  logic loadNow, beatStep, lastBeat, enterWait, waitStep, waitNext, rawWait;

  assign lenNow    = decodeLen(cfgLen);
  assign loadNow   = startReq & chipSel & ~cfgAsync;
  assign beatStep  = active & ~inWait & outEn;
  assign lastBeat  = ~contMode & (beatsLeft == BEAT_W'(1));
  assign enterWait = ~wrapEff & atBlockEnd & (waitLeft != '0);
  assign waitStep  = active & inWait & outEn;

  always_comb begin
    strobe.load     = loadNow;
    strobe.advance  = beatStep & ~lastBeat & ~loadNow;
    strobe.wrapEn   = wrapEff;
    strobe.wrapMask = maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      inWait    <= 1'b0;
      contMode  <= 1'b0;
      wrapEff   <= 1'b0;
      waitLeft  <= '0;
      beatsLeft <= '0;
      maskQ     <= '0;
    end else if (!chipSel) begin
      active <= 1'b0;
      inWait <= 1'b0;
    end else if (loadNow) begin
      active    <= 1'b1;
      inWait    <= 1'b0;
      contMode  <= lenNow.cont;
      wrapEff   <= cfgWrap & ~lenNow.cont;
      maskQ     <= lenNow.mask;
      beatsLeft <= lenNow.beats;
      waitLeft  <= (cfgWrap & ~lenNow.cont) ? '0 : startSkew;
    end else begin
      if (beatStep) begin
        if (lastBeat) begin
          active <= 1'b0;
        end else begin
          if (!contMode) beatsLeft <= beatsLeft - BEAT_W'(1);
          if (enterWait) inWait <= 1'b1;
        end
      end
      if (waitStep) begin
        waitLeft <= waitLeft - SKEW_W'(1);
        if (waitLeft == SKEW_W'(1)) inWait <= 1'b0;
      end
    end
  end

  // look-ahead: the next presented cycle is a wait cycle
  assign waitNext = active & ((inWait & (waitLeft > SKEW_W'(1))) |
                              (~inWait & ~lastBeat & enterWait));
  assign rawWait   = cfgWaitEarly ? waitNext : (active & inWait);
  assign beatValid = active & ~inWait;
  assign rdyWaitOe = chipSel;
  assign rdyWait   = chipSel & (cfgWaitPol ? rawWait : ~rawWait);

  AST_WAIT_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    inWait |-> (waitLeft != '0)); // R6
  AST_NO_WAIT_IN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    wrapEff |-> !inWait); // R4
  AST_ASYNC_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!active && cfgAsync) |=> !active); // R11
  AST_DESELECT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !active); // R12
  AST_FINITE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (active && !contMode) |-> (beatsLeft != '0)); // R3
  AST_CONT_LINEAR: assert property (@(posedge clk) disable iff (!rstN)
    contMode |-> !wrapEff); // R7
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              cfgAsync,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgWrap,
  input  logic              cfgWaitPol,
  input  logic              cfgWaitEarly,
  input  logic              chipSel,
  input  logic              outEn,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              beatValid,
  output logic              rdyWait,
  output logic              rdyWaitOe
);
  seqStrobe_t strobe;
  logic       atBlockEnd;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startSkew(startAddr[SKEW_W-1:0]),
    .cfgAsync(cfgAsync), .cfgLen(cfgLen), .cfgWrap(cfgWrap), .cfgWaitPol(cfgWaitPol),
    .cfgWaitEarly(cfgWaitEarly), .chipSel(chipSel), .outEn(outEn), .atBlockEnd(atBlockEnd),
    .strobe(strobe), .beatValid(beatValid), .rdyWait(rdyWait), .rdyWaitOe(rdyWaitOe)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .wordAddr(wordAddr), .atBlockEnd(atBlockEnd)
  );

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !outEn && !startReq) |=> $stable(wordAddr)); // R10
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 23;

  logic          clk = 1'b0;
  logic          rstN;
  logic          startReq;
  logic [AW-1:0] startAddr;
  logic          cfgAsync, cfgWrap, cfgWaitPol, cfgWaitEarly, chipSel, outEn;
  logic [2:0]    cfgLen;
  logic [AW-1:0] wordAddr;
  logic          beatValid, rdyWait, rdyWaitOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int expQ[$];

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .cfgAsync(cfgAsync), .cfgLen(cfgLen), .cfgWrap(cfgWrap), .cfgWaitPol(cfgWaitPol),
    .cfgWaitEarly(cfgWaitEarly), .chipSel(chipSel), .outEn(outEn),
    .wordAddr(wordAddr), .beatValid(beatValid), .rdyWait(rdyWait), .rdyWaitOe(rdyWaitOe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one burst; expQ holds addresses, -1 marks a wait cycle.
  task automatic runBurst(input logic [AW-1:0] st, input logic [2:0] len, input bit wrap,
                          input bit early, input bit pol, input bit finite, input string req);
    int n = expQ.size();
    @(negedge clk);
    cfgLen = len; cfgWrap = wrap; cfgWaitEarly = early; cfgWaitPol = pol;
    startAddr = st; startReq = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      startReq = 1'b0;
      begin
        bit isWait = (expQ[i] == -1);
        bit asserted = early ? ((i + 1 < n) && (expQ[i+1] == -1)) : isWait;
        check(beatValid == !isWait, req, "beatValid", beatValid, !isWait);
        if (!isWait) check(wordAddr == AW'(expQ[i]), req, "wordAddr", wordAddr, expQ[i]);
        check(rdyWait == (asserted ? pol : !pol), "R8/R9", "rdyWait", rdyWait, asserted ? pol : !pol);
      end
    end
    if (finite) begin
      @(negedge clk);
      check(beatValid == 1'b0, "R3", "burst end", beatValid, 0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(beatValid == 1'b0, "R1", "beatValid after reset", beatValid, 0);
    check(rdyWait == ~cfgWaitPol, "R1", "rdyWait idle level", rdyWait, ~cfgWaitPol);
  endtask

  task automatic testWrap4();
    expQ = '{'h101, 'h102, 'h103, 'h100};
    runBurst('h101, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, "R4 wrap4 off1");
    expQ = '{'h102, 'h103, 'h100, 'h101};
    runBurst('h102, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, "R4 wrap4 off2");
  endtask

  task automatic testWrapLong();
    expQ = '{'h2D, 'h2E, 'h2F, 'h28, 'h29, 'h2A, 'h2B, 'h2C};
    runBurst('h2D, 3'b010, 1'b1, 1'b0, 1'b1, 1'b1, "R4 wrap8");
    expQ = {};
    for (int k = 0; k < 16; k++) expQ.push_back('h3D0 + ((13 + k) % 16));
    runBurst('h3DD, 3'b011, 1'b1, 1'b1, 1'b0, 1'b1, "R4 wrap16 no waits");
  endtask

  task automatic testLinear();
    expQ = '{'h201, 'h202, 'h203, 'h204};
    runBurst('h201, 3'b001, 1'b0, 1'b0, 1'b1, 1'b1, "R5 linear4 off1");
    expQ = '{'h20D, 'h20E, 'h20F, -1, 'h210};
    runBurst('h20D, 3'b001, 1'b0, 1'b0, 1'b1, 1'b1, "R6 linear off13 late");
    expQ = '{'h20E, 'h20F, -1, -1, 'h210, 'h211};
    runBurst('h20E, 3'b001, 1'b0, 1'b1, 1'b0, 1'b1, "R6 linear off14 early");
    expQ = '{'h30C, 'h30D, 'h30E, 'h30F, 'h310, 'h311, 'h312, 'h313};
    runBurst('h30C, 3'b010, 1'b0, 1'b0, 1'b1, 1'b1, "R5 aligned crossing");
  endtask

  task automatic testContinuous();
    expQ = '{'h41E, 'h41F, -1, -1};
    for (int k = 0; k < 20; k++) expQ.push_back('h420 + k);
    runBurst('h41E, 3'b111, 1'b1, 1'b1, 1'b1, 1'b0, "R7 continuous ignores wrap");
    chipSel = 1'b0;
    @(negedge clk);
    check(rdyWaitOe == 1'b0, "R12", "rdyWaitOe deselected", rdyWaitOe, 0);
    check(beatValid == 1'b0, "R12", "burst aborted", beatValid, 0);
    chipSel = 1'b1;
    @(negedge clk);
    check(rdyWaitOe == 1'b1, "R12", "rdyWaitOe selected", rdyWaitOe, 1);
    check(beatValid == 1'b0, "R12", "stays idle", beatValid, 0);
  endtask

  task automatic testPause();
    @(negedge clk);
    cfgLen = 3'b010; cfgWrap = 1'b0; cfgWaitEarly = 1'b0; cfgWaitPol = 1'b1;
    startAddr = 'h544; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    check(wordAddr == 'h544, "R2", "first beat", wordAddr, 'h544);
    @(negedge clk);
    check(wordAddr == 'h545, "R2", "second beat", wordAddr, 'h545);
    outEn = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(wordAddr == 'h545 && beatValid, "R10", "held during pause", wordAddr, 'h545);
    end
    outEn = 1'b1;
    for (int k = 6; k < 12; k++) begin
      @(negedge clk);
      check(wordAddr == AW'('h540 + k) && beatValid, "R10", "resume", wordAddr, 'h540 + k);
    end
    @(negedge clk);
    check(beatValid == 1'b0, "R10", "count held across pause", beatValid, 0);
  endtask

  task automatic testAsync();
    @(negedge clk);
    cfgAsync = 1'b1; cfgLen = 3'b001; startAddr = 'h600; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(beatValid == 1'b0, "R11", "start ignored in async", beatValid, 0);
      @(negedge clk);
    end
    cfgAsync = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; startReq = 1'b0; startAddr = '0; cfgAsync = 1'b0; cfgLen = 3'b001;
    cfgWrap = 1'b0; cfgWaitPol = 1'b1; cfgWaitEarly = 1'b0; chipSel = 1'b1; outEn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrap4();
    testWrapLong();
    testLinear();
    testContinuous();
    testPause();
    testAsync();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule